// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core. Four sources feed it: a rising edge on an external request pin, a one-cycle overflow strobe from a timer, any change on a group of port pins, and a one-cycle event strobe from a comparator peripheral. Each source owns a flag bit and an enable bit. A global enable gates all of them. The comparator source is also gated by a peripheral group enable. Software reaches the bits through a byte-wide register port.

The block drives a request line and a fixed vector address to the core. The core acknowledges entry with a strobe that drops the global enable, and a return strobe raises it again. Flags are never cleared by hardware. A wake output tells a sleeping core that some enabled flag is set, whatever the global enable holds. A write that clears the global enable hides the request during that cycle and marks the next cycle as a no-operation slot. The request stays pending until the global enable is set again.

Top module: `intc_top`

## Requirements
- R1: After a synchronous active-high reset, the control register (address 0), the peripheral flag register (address 1, bit 0) and the peripheral enable register (address 2, bit 0) all read 0. irq, wake and nopSlot are low.
- R2: A flag sets on its event whatever its own enable bit and the global enable hold. A tmrOvf pulse sets control bit 5, and a cmpEvt pulse sets peripheral flag bit 0, on the next clock edge.
- R3: irq is high exactly when the global enable (control bit 7) is set and at least one enabled source is pending. The enable bits are ext 0, timer 1, port 2. The flag bits are ext 4, timer 5, port 6. The comparator counts only when its flag, its enable and the group enable (control bit 3) are all set.
- R4: An irqAck pulse clears the global enable on the next edge and leaves every flag unchanged.
- R5: A retStrobe pulse sets the global enable on the next edge.
- R6: Flags are cleared only by software writes. When a hardware event and a write that clears the same flag fall in one cycle, the flag ends up set.
- R7: A rising edge on extPin sets control bit 4 on the third clock edge after the pin changes, and not before. A falling edge sets nothing.
- R8: The port flag (bit 6) sets while the synchronized pins differ from a latched copy. A read of address 3 returns the synchronized pins and loads them into the latched copy.
- R9: A control write with bit 7 low forces irq low in that same cycle and raises nopSlot for the following cycle. The request then stays pending and irq returns once the global enable is set again.
- R10: wake is high whenever any enabled source is pending, including while the global enable is clear.
- R11: vector always carries the fixed entry address 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| extPin | input | 1 | External request pin (asynchronous) |
| portPins | input | PORT_W | Watched port pins (asynchronous) |
| tmrOvf | input | 1 | Timer overflow strobe |
| cmpEvt | input | 1 | Comparator event strobe |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data (combinational) |
| irqAck | input | 1 | Core has taken the interrupt |
| retStrobe | input | 1 | Core has returned from the handler |
| irq | output | 1 | Interrupt request to the core |
| vector | output | VEC_W | Handler entry address |
| wake | output | 1 | Wake-up request for sleep mode |
| nopSlot | output | 1 | Cycle after a global-enable clear |

## Verification
The bench looks at the cycle in which the global enable is cleared. A design that checked the old enable there would raise irq in that cycle, and one that cleared the flag would lose the pending request after re-enabling. It times the pin edge to the exact edge. An extra or missing synchronizer stage moves the flag a cycle away, and a detector that reacts to both edges sets the flag on the falling edge. It also covers an event that meets a clearing write in the same cycle, where a design with the wrong priority drops the event. It checks the peripheral group enable, which a design might skip and so raise irq or wake too early. Finally it checks that a port read refreshes the latched copy, since a design that never did so would keep setting the port flag.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PFLAG = 2'd1,
    REG_PEN   = 2'd2,
    REG_PORT  = 2'd3
  } regSel_e;

  localparam int B_EXT_EN  = 0;
  localparam int B_TMR_EN  = 1;
  localparam int B_PORT_EN = 2;
  localparam int B_GRP_EN  = 3;
  localparam int B_EXT_F   = 4;
  localparam int B_TMR_F   = 5;
  localparam int B_PORT_F  = 6;
  localparam int B_GIE     = 7;

  typedef struct packed {
    logic setExt;
    logic setTmr;
    logic setPort;
    logic setCmp;
    logic clrGie;
    logic setGie;
  } evtStrobe_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic              tmrOvf,
  input  logic              cmpEvt,
  input  logic              irqAck,
  input  logic              retStrobe,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic              wrGieBit,
  input  logic              gie,
  input  logic              pendEn,
  output evtStrobe_t        strobes,
  output logic [PORT_W-1:0] portSync,
  output logic              irq,
  output logic              wake,
  output logic              nopSlot
);
  logic extSync;
  logic extPrev;
  logic [PORT_W-1:0] portLatch;
  logic gieClearWr;

  intc_sync #(.W(1), .STAGES(SYNC_STAGES)) i_extSync (
    .clk(clk), .rst(rst), .din(extPin), .dout(extSync)
  );

  intc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_portSync (
    .clk(clk), .rst(rst), .din(portPins), .dout(portSync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      extPrev   <= 1'b0;
      portLatch <= '0;
      nopSlot   <= 1'b0;
    end else begin
      extPrev <= extSync;
      if (rdEn && addr == REG_PORT) portLatch <= portSync;
      nopSlot <= gieClearWr;
    end
  end

  assign gieClearWr = wrEn && (addr == REG_CTRL) && !wrGieBit;

  always_comb begin
    strobes.setExt  = extSync & ~extPrev;
    strobes.setTmr  = tmrOvf;
    strobes.setPort = |(portSync ^ portLatch);
    strobes.setCmp  = cmpEvt;
    strobes.clrGie  = irqAck;
    strobes.setGie  = retStrobe;
  end

  assign irq  = gie & pendEn & ~gieClearWr;
  assign wake = pendEn;
endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  evtStrobe_t        strobes,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PORT_W-1:0] portSync,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              gie,
  output logic              pendEn
);
  logic [DATA_W-1:0] ctrlQ, ctrlNext;
  logic pFlagQ, pFlagNext;
  logic pEnQ;
  logic wrCtrl;

  assign wrCtrl = wrEn && (addr == REG_CTRL);

  always_comb begin
    ctrlNext = ctrlQ;
    if (wrCtrl)              ctrlNext = wrData;
    else if (strobes.clrGie) ctrlNext[B_GIE] = 1'b0;
    else if (strobes.setGie) ctrlNext[B_GIE] = 1'b1;
    if (strobes.setExt)  ctrlNext[B_EXT_F]  = 1'b1;
    if (strobes.setTmr)  ctrlNext[B_TMR_F]  = 1'b1;
    if (strobes.setPort) ctrlNext[B_PORT_F] = 1'b1;

    pFlagNext = pFlagQ;
    if (wrEn && addr == REG_PFLAG) pFlagNext = wrData[0];
    if (strobes.setCmp)            pFlagNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ  <= '0;
      pFlagQ <= 1'b0;
      pEnQ   <= 1'b0;
    end else begin
      ctrlQ  <= ctrlNext;
      pFlagQ <= pFlagNext;
      if (wrEn && addr == REG_PEN) pEnQ <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      REG_CTRL:  rdData = ctrlQ;
      REG_PFLAG: rdData[0] = pFlagQ;
      REG_PEN:   rdData[0] = pEnQ;
      default:   rdData[PORT_W-1:0] = portSync;
    endcase
  end

  assign pendEn = (ctrlQ[B_EXT_F]  & ctrlQ[B_EXT_EN])
                | (ctrlQ[B_TMR_F]  & ctrlQ[B_TMR_EN])
                | (ctrlQ[B_PORT_F] & ctrlQ[B_PORT_EN])
                | (pFlagQ & pEnQ & ctrlQ[B_GRP_EN]);
  assign gie     = ctrlQ[B_GIE];
  assign ctrlReg = ctrlQ;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int PORT_W = 4,
  parameter int VEC_W  = 13,
  parameter logic [VEC_W-1:0] VECTOR = 13'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extPin,
  input  logic [PORT_W-1:0] portPins,
  input  logic              tmrOvf,
  input  logic              cmpEvt,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              irqAck,
  input  logic              retStrobe,
  output logic              irq,
  output logic [VEC_W-1:0]  vector,
  output logic              wake,
  output logic              nopSlot
);
  localparam int DATA_W = 8;

  evtStrobe_t strobes;
  logic [PORT_W-1:0] portSync;
  logic [DATA_W-1:0] ctrlReg;
  logic gie;
  logic pendEn;

  intc_ctrl #(.PORT_W(PORT_W)) i_ctrl (
    .clk(clk), .rst(rst), .extPin(extPin), .portPins(portPins),
    .tmrOvf(tmrOvf), .cmpEvt(cmpEvt), .irqAck(irqAck), .retStrobe(retStrobe),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrGieBit(wrData[B_GIE]),
    .gie(gie), .pendEn(pendEn), .strobes(strobes), .portSync(portSync),
    .irq(irq), .wake(wake), .nopSlot(nopSlot)
  );

  intc_dp #(.PORT_W(PORT_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .portSync(portSync), .rdData(rdData),
    .ctrlReg(ctrlReg), .gie(gie), .pendEn(pendEn)
  );

  assign vector = VECTOR;
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic       clk,
  input logic       rst,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic       irqAck,
  input logic       retStrobe,
  input logic       tmrOvf,
  input logic       irq,
  input logic       wake,
  input logic       nopSlot,
  input logic [7:0] ctrlReg
);
  logic wrCtrl;
  assign wrCtrl = wrEn && (addr == 2'd0);

  // R2
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    tmrOvf |=> ctrlReg[5]);

  // R3
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrlReg[7]);

  // R4
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (irqAck && !wrCtrl) |=> !ctrlReg[7]);

  // R5
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (retStrobe && !irqAck && !wrCtrl) |=> ctrlReg[7]);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrlReg[5] && !wrCtrl) |=> ctrlReg[5]);

  // R9
  clear_masks_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wrCtrl && !wrData[7]) |-> !irq);

  // R9
  nop_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wrCtrl && !wrData[7]) |=> nopSlot);

  // R10
  wake_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> wake);
endmodule

bind intc_top intc_chk i_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqAck(irqAck), .retStrobe(retStrobe), .tmrOvf(tmrOvf), .irq(irq),
  .wake(wake), .nopSlot(nopSlot), .ctrlReg(ctrlReg)
);

// File: tb/test_intc_top.sv
module test_intc_top;
  localparam int PORT_W = 4;
  localparam int VEC_W  = 13;
  localparam int K_RD = 0, K_IRQ = 1, K_WAKE = 2, K_NOP = 3, K_VEC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic extPin = 1'b0;
  logic [PORT_W-1:0] portPins = '0;
  logic tmrOvf = 1'b0, cmpEvt = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic irqAck = 1'b0, retStrobe = 1'b0;
  logic irq, wake, nopSlot;
  logic [VEC_W-1:0] vector;

  typedef struct {
    string req;
    int    kind;
    logic [15:0] exp;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rst(rst), .extPin(extPin), .portPins(portPins),
    .tmrOvf(tmrOvf), .cmpEvt(cmpEvt), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqAck(irqAck),
    .retStrobe(retStrobe), .irq(irq), .vector(vector), .wake(wake),
    .nopSlot(nopSlot)
  );

  // monitor: pops expectations in the middle of the cycle they belong to
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = {8'd0, rdData};
        K_IRQ:   act = {15'd0, irq};
        K_WAKE:  act = {15'd0, wake};
        K_NOP:   act = {15'd0, nopSlot};
        default: act = {3'd0, vector};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input string req, input int kind, input logic [15:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rdEn = 1'b1; addr = a;
    expect_item(req, K_RD, {8'd0, exp});
    step();
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state, R11 vector
    rdchk("R1", 2'd0, 8'h00);
    rdchk("R1", 2'd1, 8'h00);
    rdchk("R1", 2'd2, 8'h00);
    expect_item("R1", K_IRQ, 0);
    expect_item("R1", K_WAKE, 0);
    expect_item("R1", K_NOP, 0);
    expect_item("R11", K_VEC, 16'h0004);
    step();

    // R2 timer flag sets with everything masked
    tmrOvf = 1'b1; step(); tmrOvf = 1'b0;
    rdchk("R2", 2'd0, 8'h20);
    expect_item("R2", K_IRQ, 0);
    expect_item("R2", K_WAKE, 0);
    step();

    // R6 hardware never clears; software clears; event beats clear
    repeat (3) step();
    rdchk("R6", 2'd0, 8'h20);
    wr(2'd0, 8'h00);
    rdchk("R6", 2'd0, 8'h00);
    tmrOvf = 1'b1; wr(2'd0, 8'h00); tmrOvf = 1'b0;
    rdchk("R6", 2'd0, 8'h20);
    wr(2'd0, 8'h00);

    // R3 comparator path needs group enable
    cmpEvt = 1'b1; step(); cmpEvt = 1'b0;
    rdchk("R2", 2'd1, 8'h01);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h80);
    expect_item("R3", K_IRQ, 0);
    expect_item("R3", K_WAKE, 0);
    step();
    wr(2'd0, 8'h88);
    expect_item("R3", K_IRQ, 1);
    expect_item("R10", K_WAKE, 1);
    step();

    // R4 ack drops global enable, flag kept
    irqAck = 1'b1; step(); irqAck = 1'b0;
    rdchk("R4", 2'd0, 8'h08);
    rdchk("R4", 2'd1, 8'h01);
    expect_item("R4", K_IRQ, 0);
    expect_item("R10", K_WAKE, 1);
    step();

    // R5 return raises global enable
    retStrobe = 1'b1; step(); retStrobe = 1'b0;
    rdchk("R5", 2'd0, 8'h88);
    expect_item("R5", K_IRQ, 1);
    step();

    // R9 clearing write: masked now, nop slot next, pending afterwards
    wrEn = 1'b1; addr = 2'd0; wrData = 8'h08;
    expect_item("R9", K_IRQ, 0);
    step();
    wrEn = 1'b0;
    expect_item("R9", K_NOP, 1);
    expect_item("R9", K_IRQ, 0);
    step();
    expect_item("R9", K_NOP, 0);
    step();
    wr(2'd0, 8'h88);
    expect_item("R9", K_IRQ, 1);
    step();
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R7 external pin: flag on the third edge, falling edge ignored
    extPin = 1'b1;
    step(); step();
    rdchk("R7", 2'd0, 8'h00);
    rdchk("R7", 2'd0, 8'h10);
    wr(2'd0, 8'h00);
    extPin = 1'b0;
    repeat (4) step();
    rdchk("R7", 2'd0, 8'h00);

    // R8 port change against latched copy
    portPins = 4'b0101;
    repeat (4) step();
    rdchk("R8", 2'd0, 8'h40);
    rdchk("R8", 2'd3, 8'h05);
    wr(2'd0, 8'h00);
    repeat (2) step();
    rdchk("R8", 2'd0, 8'h00);
    portPins = 4'b0100;
    repeat (4) step();
    rdchk("R8", 2'd0, 8'h40);
    rdchk("R8", 2'd3, 8'h04);

    // R10 wake without global enable, then R3 with it
    wr(2'd0, 8'h44);
    expect_item("R10", K_WAKE, 1);
    expect_item("R10", K_IRQ, 0);
    step();
    wr(2'd0, 8'hC4);
    expect_item("R3", K_IRQ, 1);
    step();

    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule